// File: doc/BRIEF.md
# Lamp Ballast Mode Sequencer

This block is the control state machine of a resonant lamp ballast. It takes digitised comparator flags for supply, bus voltage, shutdown, temperature and half-bridge current. It moves the ballast from a stopped state through filament preheat and the ignition sweep into steady run. It also decides when a fault stops the bridge and how the ballast recovers. The analog comparators, current sources and oscillator sit outside it.

One internal counter stands in for the external preheat timing capacitor. It ramps by a fixed step on every clock while the bridge runs, and three parameter thresholds on it mark the end of preheat, the end of the ignition sweep and a saturation clamp. The outputs tell the oscillator whether to run and which frequency target to steer toward. Faults come in two kinds. A stop condition simply halts the ballast and restarts it when the condition goes away. A tripped protection latches and needs a shutdown pulse or a supply drop to release it.

Top module: `ballast_seq`

## Requirements
- R1: After reset the block reports mode 0 (stopped), oscillator enable 0, timer 0 and frequency select 3.
- R2: From stopped (mode 0), preheat (mode 1) is entered on the next edge only when all of these hold together: supply above the rising threshold, supply above the falling threshold, bus OK, bus-low clear, shutdown low and no overtemperature. Otherwise the block stays stopped.
- R3: In stopped (mode 0) and fault (mode 4) the oscillator enable is 0 and the timer reads 0.
- R4: On each edge that leaves the block in an active mode (1, 2 or 3), the timer grows by STEP. It saturates at CLAMP_CNT and never exceeds it. The first active cycle after a stop reads STEP.
- R5: Preheat goes to ignition (mode 2) on the edge after the timer reaches at least PH_CNT. Ignition goes to run (mode 3) on the edge after it reaches at least IGN_CNT.
- R6: Frequency select is 0 in preheat, 1 (sweep toward minimum) in ignition, 2 in run and 3 in stopped and fault.
- R7: In preheat, the over-current and under-current flags have no effect on the mode.
- R8: In ignition and run, the over-current flag moves the block to fault (mode 4) on the next edge.
- R9: In run, the under-current flag causes a fault only in a cycle where the LO falling-edge strobe is also high. Outside run it is ignored.
- R10: Overtemperature in any active mode moves the block to fault.
- R11: Fault is left only for stopped, and only when shutdown is high or the supply is below the falling threshold. Bus-low and the current flags keep it in fault.
- R12: In an active mode, supply below the falling threshold, shutdown high or bus-low returns the block to stopped without latching. When the start conditions return, it restarts from preheat with the timer starting again from zero.
- R13: When a stop condition and a fault trip occur in the same cycle, the stop wins and the block goes to stopped, not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vccAboveOn | input | 1 | Supply above rising lockout threshold |
| vccAboveOff | input | 1 | Supply above falling lockout threshold |
| busOk | input | 1 | Bus voltage above its upper threshold |
| busLow | input | 1 | Bus voltage below its lower threshold |
| sdHigh | input | 1 | Shutdown (lamp sense) input high |
| overTemp | input | 1 | Overtemperature detected |
| csOver | input | 1 | Current sense above the positive threshold |
| csUnder | input | 1 | Current sense below the negative threshold |
| loFallStrobe | input | 1 | One-cycle strobe on the low-side gate falling edge |
| mode | output | 3 | 0 stopped, 1 preheat, 2 ignition, 3 run, 4 fault |
| oscEn | output | 1 | Oscillator enable |
| freqSel | output | 2 | Frequency target: 0 preheat, 1 sweep, 2 run, 3 idle |
| phTimer | output | TMR_W | Preheat timer value |

## Verification
Directed sequences first walk one full start. They hold each start condition missing in turn and show the block stays stopped. They then show the current flags are inert in preheat and that the mode changes at the exact timer values where preheat and ignition end. Further sequences separate the two under-current cases, with and without the LO strobe, and the two recovery paths out of fault: shutdown and supply drop. Bus-low is shown to leave the latch alone. One case raises a stop condition together with a trip to confirm the stop wins. Biased random runs then mix all flags at low rates, so the block keeps reaching run and is tripped, stopped and restarted from many timer values. Every cycle is compared against a bench model built from the requirements.

// File: rtl/ballast_pkg.sv
package ballast_pkg;

  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_PREHEAT = 3'd1,
    MODE_IGNITE  = 3'd2,
    MODE_RUN     = 3'd3,
    MODE_FAULT   = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    FSEL_PREHEAT = 2'd0,
    FSEL_SWEEP   = 2'd1,
    FSEL_RUN     = 2'd2,
    FSEL_IDLE    = 2'd3
  } fsel_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic tmrClear;
    logic tmrAdvance;
  } tmr_ctl_s;

  // threshold flags from the timer datapath back to control
  typedef struct packed {
    logic phDone;
    logic ignDone;
  } tmr_flags_s;

endpackage

// File: rtl/ballast_timer.sv
module ballast_timer
  import ballast_pkg::*;
#(
  parameter int TMR_W     = 16,
  parameter int STEP      = 1,
  parameter int PH_CNT    = 400,
  parameter int IGN_CNT   = 510,
  parameter int CLAMP_CNT = 760
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_ctl_s         ctl,
  output logic [TMR_W-1:0] cnt,
  output tmr_flags_s       flags
);

  localparam logic [TMR_W:0]   STEP_X  = (TMR_W+1)'(STEP);
  localparam logic [TMR_W:0]   CLAMP_X = (TMR_W+1)'(CLAMP_CNT);
  localparam logic [TMR_W-1:0] PH_T    = TMR_W'(PH_CNT);
  localparam logic [TMR_W-1:0] IGN_T   = TMR_W'(IGN_CNT);
  localparam logic [TMR_W-1:0] CLAMP_T = TMR_W'(CLAMP_CNT);

  logic [TMR_W:0]   sum;
  logic [TMR_W-1:0] cntNext;

  always_comb begin
    sum = {1'b0, cnt} + STEP_X;
    if (ctl.tmrClear)        cntNext = '0;
    else if (!ctl.tmrAdvance) cntNext = cnt;
    else if (sum >= CLAMP_X) cntNext = CLAMP_T;
    else                     cntNext = sum[TMR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cntNext;
  end

  assign flags.phDone  = (cnt >= PH_T);
  assign flags.ignDone = (cnt >= IGN_T);

endmodule

// File: rtl/ballast_ctrl.sv
module ballast_ctrl
  import ballast_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vccAboveOn,
  input  logic       vccAboveOff,
  input  logic       busOk,
  input  logic       busLow,
  input  logic       sdHigh,
  input  logic       overTemp,
  input  logic       csOver,
  input  logic       csUnder,
  input  logic       loFallStrobe,
  input  tmr_flags_s flags,
  output mode_e      modeQ,
  output tmr_ctl_s   ctl,
  output logic       oscEn,
  output fsel_e      freqSel
);

  mode_e modeNext;
  logic  stopReq;
  logic  startOk;
  logic  tripReq;
  logic  nextActive;

  always_comb begin
    stopReq = !vccAboveOff || sdHigh || busLow;
    startOk = vccAboveOn && busOk && !sdHigh && !overTemp;
    tripReq = overTemp
            || (csOver && (modeQ == MODE_IGNITE || modeQ == MODE_RUN))
            || (csUnder && loFallStrobe && modeQ == MODE_RUN);
  end

  always_comb begin
    modeNext = modeQ;
    unique case (modeQ)
      MODE_OFF: begin
        if (!stopReq && startOk) modeNext = MODE_PREHEAT;
      end
      MODE_FAULT: begin
        // only a shutdown pulse or supply drop releases the latch
        if (!vccAboveOff || sdHigh) modeNext = MODE_OFF;
      end
      MODE_PREHEAT, MODE_IGNITE, MODE_RUN: begin
        if (stopReq)      modeNext = MODE_OFF;
        else if (tripReq) modeNext = MODE_FAULT;
        else if (modeQ == MODE_PREHEAT && flags.phDone)  modeNext = MODE_IGNITE;
        else if (modeQ == MODE_IGNITE  && flags.ignDone) modeNext = MODE_RUN;
      end
      default: modeNext = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_OFF;
    else       modeQ <= modeNext;
  end

  always_comb begin
    nextActive     = (modeNext == MODE_PREHEAT) || (modeNext == MODE_IGNITE)
                   || (modeNext == MODE_RUN);
    ctl.tmrClear   = !nextActive;
    ctl.tmrAdvance = nextActive;
  end

  always_comb begin
    oscEn = 1'b0;
    unique case (modeQ)
      MODE_PREHEAT: begin freqSel = FSEL_PREHEAT; oscEn = 1'b1; end
      MODE_IGNITE:  begin freqSel = FSEL_SWEEP;   oscEn = 1'b1; end
      MODE_RUN:     begin freqSel = FSEL_RUN;     oscEn = 1'b1; end
      default:      freqSel = FSEL_IDLE;
    endcase
  end

endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
  import ballast_pkg::*;
#(
  parameter int TMR_W     = 16,
  parameter int STEP      = 1,
  parameter int PH_CNT    = 400,
  parameter int IGN_CNT   = 510,
  parameter int CLAMP_CNT = 760
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vccAboveOn,
  input  logic             vccAboveOff,
  input  logic             busOk,
  input  logic             busLow,
  input  logic             sdHigh,
  input  logic             overTemp,
  input  logic             csOver,
  input  logic             csUnder,
  input  logic             loFallStrobe,
  output logic [2:0]       mode,
  output logic             oscEn,
  output logic [1:0]       freqSel,
  output logic [TMR_W-1:0] phTimer
);

  generate
    if (!(STEP > 0 && PH_CNT < IGN_CNT && IGN_CNT < CLAMP_CNT
          && (CLAMP_CNT + STEP) < (2 ** TMR_W))) begin : g_badCfg
      $error("ballast_seq: thresholds must rise strictly and fit the timer");
    end
  endgenerate

  tmr_ctl_s   tmrCtl;
  tmr_flags_s tmrFlags;
  mode_e      modeQ;
  fsel_e      fsel;

  ballast_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .vccAboveOn   (vccAboveOn),
    .vccAboveOff  (vccAboveOff),
    .busOk        (busOk),
    .busLow       (busLow),
    .sdHigh       (sdHigh),
    .overTemp     (overTemp),
    .csOver       (csOver),
    .csUnder      (csUnder),
    .loFallStrobe (loFallStrobe),
    .flags        (tmrFlags),
    .modeQ        (modeQ),
    .ctl          (tmrCtl),
    .oscEn        (oscEn),
    .freqSel      (fsel)
  );

  ballast_timer #(
    .TMR_W     (TMR_W),
    .STEP      (STEP),
    .PH_CNT    (PH_CNT),
    .IGN_CNT   (IGN_CNT),
    .CLAMP_CNT (CLAMP_CNT)
  ) u_timer (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (tmrCtl),
    .cnt   (phTimer),
    .flags (tmrFlags)
  );

  assign mode    = modeQ;
  assign freqSel = fsel;

endmodule

// File: rtl/ballast_seq_chk.sv
module ballast_seq_chk #(
  parameter int TMR_W     = 16,
  parameter int STEP      = 1,
  parameter int CLAMP_CNT = 760
) (
  input logic             clk,
  input logic             rstN,
  input logic             vccAboveOn,
  input logic             vccAboveOff,
  input logic             busOk,
  input logic             busLow,
  input logic             sdHigh,
  input logic             overTemp,
  input logic             csOver,
  input logic             csUnder,
  input logic             loFallStrobe,
  input logic [2:0]       mode,
  input logic             oscEn,
  input logic [TMR_W-1:0] phTimer
);

  localparam logic [TMR_W:0] CLAMP_X = (TMR_W+1)'(CLAMP_CNT);
  localparam logic [TMR_W:0] STEP_X  = (TMR_W+1)'(STEP);

  // R3
  idle_timer_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd0 || mode == 3'd4) |-> (phTimer == '0));

  // R4
  timer_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, phTimer} <= CLAMP_X));

  // R4
  timer_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oscEn && ({1'b0, phTimer} + STEP_X <= CLAMP_X)) |=>
      (!oscEn || ({1'b0, phTimer} == {1'b0, $past(phTimer)} + STEP_X)));

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd0 && !(vccAboveOn && busOk && !sdHigh && !overTemp)) |=> (mode == 3'd0));

  // R7
  preheat_immune_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd1 && !overTemp) |=> (mode != 3'd4));

  // R9
  under_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd3 && csUnder && !loFallStrobe && !csOver && !overTemp) |=> (mode != 3'd4));

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd4 && vccAboveOff && !sdHigh) |=> (mode == 3'd4));

  // R13
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 3'd1 || mode == 3'd2 || mode == 3'd3) && (sdHigh || busLow || !vccAboveOff))
      |=> (mode == 3'd0));

endmodule

bind ballast_seq ballast_seq_chk #(
  .TMR_W     (TMR_W),
  .STEP      (STEP),
  .CLAMP_CNT (CLAMP_CNT)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .vccAboveOn   (vccAboveOn),
  .vccAboveOff  (vccAboveOff),
  .busOk        (busOk),
  .busLow       (busLow),
  .sdHigh       (sdHigh),
  .overTemp     (overTemp),
  .csOver       (csOver),
  .csUnder      (csUnder),
  .loFallStrobe (loFallStrobe),
  .mode         (mode),
  .oscEn        (oscEn),
  .phTimer      (phTimer)
);

// File: tb/sim_ballast_seq.sv
`timescale 1ns/1ps
module sim_ballast_seq;

  localparam int W     = 8;
  localparam int STEP  = 3;
  localparam int PH    = 40;
  localparam int IGN   = 52;
  localparam int CLAMP = 76;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vOn = 0, vOff = 0, bOk = 0, bLow = 0, sd = 0, ot = 0, csO = 0, csU = 0, strobe = 0;
  logic [2:0]   mode;
  logic         oscEn;
  logic [1:0]   freqSel;
  logic [W-1:0] phTimer;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mMode = 0;
  int mTmr = 0;
  string mTag = "R1";

  always #2 clk = ~clk;

  ballast_seq #(.TMR_W(W), .STEP(STEP), .PH_CNT(PH), .IGN_CNT(IGN), .CLAMP_CNT(CLAMP)) u0 (
    .clk(clk), .rstN(rstN), .vccAboveOn(vOn), .vccAboveOff(vOff), .busOk(bOk),
    .busLow(bLow), .sdHigh(sd), .overTemp(ot), .csOver(csO), .csUnder(csU),
    .loFallStrobe(strobe), .mode(mode), .oscEn(oscEn), .freqSel(freqSel), .phTimer(phTimer));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit isActive(int m);
    return (m >= 1 && m <= 3);
  endfunction

  function automatic int fselOf(int m);
    case (m)
      1: return 0;
      2: return 1;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  // next model state from current model state and the inputs seen at the coming edge
  task automatic modelStep();
    int nm;
    bit stop;
    nm = mMode;
    stop = !vOff || sd || bLow;
    if (mMode == 0) begin
      if (!stop && vOn && bOk && !ot) begin nm = 1; mTag = "R2"; end
      else mTag = "R2";
    end else if (mMode == 4) begin
      mTag = "R11";
      if (!vOff || sd) nm = 0;
    end else begin
      if (stop) begin
        nm = 0;
        mTag = (ot || csO || (csU && strobe)) ? "R13" : "R12";
      end else if (ot) begin nm = 4; mTag = "R10"; end
      else if (csO && mMode >= 2) begin nm = 4; mTag = "R8"; end
      else if (csU && strobe && mMode == 3) begin nm = 4; mTag = "R9"; end
      else if (mMode == 1 && mTmr >= PH) begin nm = 2; mTag = "R5"; end
      else if (mMode == 2 && mTmr >= IGN) begin nm = 3; mTag = "R5"; end
      else mTag = (mMode == 1) ? "R7" : "R9";
    end
    if (isActive(nm)) mTmr = (mTmr + STEP >= CLAMP) ? CLAMP : mTmr + STEP;
    else mTmr = 0;
    mMode = nm;
  endtask

  task automatic compareAll();
    chk(mTag, "mode", int'(mode), mMode);
    chk("R4", "timer", int'(phTimer), mTmr);
    chk("R3", "oscEn", int'(oscEn), int'(isActive(mMode)));
    chk("R6", "freqSel", int'(freqSel), fselOf(mMode));
  endtask

  task automatic tick();
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic goodInputs();
    vOn = 1; vOff = 1; bOk = 1; bLow = 0; sd = 0; ot = 0; csO = 0; csU = 0; strobe = 0;
  endtask

  task automatic runUntil(int target);
    for (int i = 0; i < 200 && mMode != target; i++) tick();
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", "mode", int'(mode), 0);
    chk("R1", "oscEn", int'(oscEn), 0);
    chk("R1", "timer", int'(phTimer), 0);
    chk("R1", "freqSel", int'(freqSel), 3);

    // R2 each start condition missing in turn
    goodInputs(); sd = 1;  repeat (4) tick(); chk("R2", "mode sd", int'(mode), 0);
    goodInputs(); ot = 1;  repeat (4) tick(); chk("R2", "mode ot", int'(mode), 0);
    goodInputs(); bOk = 0; repeat (4) tick(); chk("R2", "mode bus", int'(mode), 0);
    goodInputs(); vOn = 0; repeat (4) tick(); chk("R2", "mode vcc", int'(mode), 0);

    // start, current flags inert in preheat (R7)
    goodInputs(); tick();
    chk("R2", "start mode", int'(mode), 1);
    chk("R4", "first timer", int'(phTimer), STEP);
    csO = 1; csU = 1; strobe = 1;
    runUntil(2);
    chk("R7", "left preheat to", int'(mode), 2);
    chk("R5", "ignite entry timer", int'(phTimer), 45);
    chk("R6", "sweep select", int'(freqSel), 1);
    goodInputs();
    runUntil(3);
    chk("R5", "run entry timer", int'(phTimer), 57);
    repeat (12) tick();
    chk("R4", "clamp", int'(phTimer), CLAMP);

    // R9 under-current needs the strobe
    csU = 1; strobe = 0; repeat (3) tick();
    chk("R9", "no strobe", int'(mode), 3);
    strobe = 1; tick();
    chk("R9", "strobe trip", int'(mode), 4);
    chk("R3", "fault timer", int'(phTimer), 0);

    // R11 latch holds on bus-low and cs flags, releases on shutdown
    csU = 0; strobe = 0; bLow = 1; csO = 1; repeat (3) tick();
    chk("R11", "hold", int'(mode), 4);
    bLow = 0; csO = 0; sd = 1; tick();
    chk("R11", "sd release", int'(mode), 0);
    sd = 0; tick();
    chk("R12", "restart preheat", int'(mode), 1);
    chk("R12", "restart timer", int'(phTimer), STEP);

    // R8 over-current in ignition, release by supply drop
    runUntil(2);
    csO = 1; tick();
    chk("R8", "cs over in ignite", int'(mode), 4);
    csO = 0; vOff = 0; vOn = 0; tick();
    chk("R11", "uvlo release", int'(mode), 0);

    // R10 overtemp in preheat
    goodInputs(); tick();
    ot = 1; tick();
    chk("R10", "ot trip", int'(mode), 4);
    ot = 0; sd = 1; tick(); goodInputs();

    // R13 stop beats trip
    runUntil(3);
    csO = 1; bLow = 1; tick();
    chk("R13", "stop wins", int'(mode), 0);
    goodInputs();

    // R12 supply drop in run is unlatched
    runUntil(3);
    vOff = 0; tick();
    chk("R12", "uvlo stop", int'(mode), 0);
    goodInputs(); tick();
    chk("R12", "auto restart", int'(mode), 1);

    // biased random
    for (int i = 0; i < 6000; i++) begin
      vOn    = ($urandom_range(99) < 97);
      vOff   = vOn ? 1'b1 : ($urandom_range(99) < 50);
      bOk    = ($urandom_range(99) < 96);
      bLow   = !bOk && ($urandom_range(99) < 30);
      sd     = ($urandom_range(999) < 8);
      ot     = ($urandom_range(999) < 4);
      csO    = ($urandom_range(999) < 8);
      csU    = ($urandom_range(99) < 10);
      strobe = ($urandom_range(99) < 25);
      tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule